// File: doc/BRIEF.md
# System Tick Countdown Timer

This block is a periodic down-counter with a small register port. Software loads a reload value and turns the timer on. The counter then steps down once per active tick. An active tick is either every core clock cycle or only those cycles in which a reference-tick enable pulse arrives; a control bit picks which. When the count steps from one to zero, the block sets a sticky expiry flag and can raise a one-cycle interrupt request. On the next active tick it reloads, so one period spans reload+1 ticks.

The register port answers in the same cycle it is presented, and every access is one full 32-bit word. A request marked unprivileged gets an error response and changes nothing. The calibration word comes from static inputs. A build-time parameter declares whether a reference tick exists at all. Without one, the source bit is pinned to the core clock.

Counting is governed by a three-state machine:
- **IDLE**: the counter is frozen.
- **RUN**: the counter steps on each active tick.
- **HALT**: the counter expired, or was cleared, while the reload value was zero. The enable bit still reads one.

Its transitions are:
- **start** (IDLE→RUN): a control write sets enable.
- **stop** (RUN→IDLE or HALT→IDLE): a control write clears enable.
- **expire_zero** (RUN→HALT): the counter reaches zero, or is cleared by a write, while the reload value is zero.

Top module: `periodic_down_timer`

## Requirements
- R1: After reset, control reads 0 (except the source bit, see R13), reload and current value read 0, the interrupt output is low, and the machine is in IDLE.
- R2: The control word at offset 0x0 has these fields:
  - bit 0 enables counting;
  - bit 1 enables the interrupt;
  - bit 2 selects the source (1 = every core clock, 0 = cycles with `ref_tick_i` high);
  - bit 16 is the expiry flag.
  
  A write changes only bits 2:0, and all other bits read 0.
- R3: A privileged read of the control word returns the flag and clears it afterwards. An expiry in the same cycle wins, so the flag stays set.
- R4: The reload register (offset 0x4) keeps only the low CNT_W bits of a write and reads back zero-extended.
- R5: In RUN, the counter at offset 0x8 (zero-extended) decreases by one per active tick, so only ticks of the selected source count.
- R6: A step from 1 to 0 sets the flag. If interrupt enable is 1, `irq_o` is high for exactly the following cycle. Loading zero or writing the counter raises neither.
- R7: An active tick that finds the counter at zero loads the reload value; the reload never happens in the same cycle as the expiry.
- R8: A write of any data to offset 0x8 sets the counter to 0 and clears the flag, with no expiry event. If the reload value is 0 in RUN, the machine takes expire_zero.
- R9: An expiry with reload value 0 enters HALT: counting stops and enable still reads 1. Only a stop followed by a start resumes counting.
- R10: Clearing enable freezes the counter at its value; setting it again resumes from that value.
- R11: An access with `req_user_i` high returns `rsp_err_o`=1 and read data 0, and changes no state.
- R12: Reads at any other offset return 0, and writes there change nothing.
- R13: With HAS_REF=0, the source bit reads 1 after reset and after every control write, and `ref_tick_i` has no effect. The calibration word then reads 0x8000_0000.
- R14: With HAS_REF=1, the calibration word at offset 0xC reads:
  - bit 31 = 0;
  - bit 30 = `cal_inexact_i`;
  - bits 29:24 = 0;
  - bits 23:0 = `cal_count_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Reference tick enable pulse, synchronous to clk |
| cal_count_i | input | 24 | Static tick count for ten milliseconds, minus one |
| cal_inexact_i | input | 1 | Static flag: the ten-millisecond count is not exact |
| req_valid_i | input | 1 | Register access present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_user_i | input | 1 | Access is unprivileged |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, same cycle |
| rsp_err_o | output | 1 | Error response, same cycle |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench builds two instances:
- **Default instance** (HAS_REF=1, CNT_W=24). A behavioural model follows it every clock. This instance reaches source switching, sparse reference ticks, read-clear races and both halt paths.
- **Second instance** (HAS_REF=0, CNT_W=8). It brings within reach the forced source bit, the calibration word without a reference, and truncation of reload bits above bit 7, using only short counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W = 32;

    localparam int OFS_CTRL   = 'h0;
    localparam int OFS_RELOAD = 'h4;
    localparam int OFS_CUR    = 'h8;
    localparam int OFS_CAL    = 'hC;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_IE_BIT   = 1;
    localparam int CTL_SRC_BIT  = 2;
    localparam int CTL_FLAG_BIT = 16;

    localparam int CAL_NOREF_BIT   = 31;
    localparam int CAL_INEXACT_BIT = 30;
    localparam int CAL_CNT_W       = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
    parameter int ADDR_W = 4
) (
    input  logic              valid,
    input  logic              write,
    input  logic              user,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_err,
    output logic              rd_ok,
    output logic              wr_ctrl,
    output logic              wr_reload,
    output logic              wr_cur,
    output logic              rd_ctrl,
    output logic              sel_ctrl,
    output logic              sel_reload,
    output logic              sel_cur,
    output logic              sel_cal
);
    import tmr_pkg::*;

    logic priv_ok;

    assign priv_ok    = valid & ~user;
    assign acc_err    = valid & user;
    assign rd_ok      = priv_ok & ~write;

    assign sel_ctrl   = (addr == ADDR_W'(OFS_CTRL));
    assign sel_reload = (addr == ADDR_W'(OFS_RELOAD));
    assign sel_cur    = (addr == ADDR_W'(OFS_CUR));
    assign sel_cal    = (addr == ADDR_W'(OFS_CAL));

    assign wr_ctrl    = priv_ok & write & sel_ctrl;
    assign wr_reload  = priv_ok & write & sel_reload;
    assign wr_cur     = priv_ok & write & sel_cur;
    assign rd_ctrl    = rd_ok & sel_ctrl;
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int HAS_REF = 1
) (
    input  logic src_core,
    input  logic ref_tick,
    output logic tick_en
);
    generate
        if (HAS_REF != 0) begin : g_ref
            assign tick_en = src_core | ref_tick;
        end else begin : g_noref
            logic unused_ref;
            assign unused_ref = ref_tick;
            assign tick_en    = src_core;
        end
    endgenerate
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W   = 24,
    parameter int HAS_REF = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wr_ctrl,
    input  logic                wr_reload,
    input  logic                wr_cur,
    input  logic                rd_ctrl,
    input  logic [2:0]          ctl_wdata,
    input  logic [CNT_W-1:0]    rel_wdata,
    output logic [CNT_W-1:0]    count_o,
    output logic [CNT_W-1:0]    reload_o,
    output logic                en_o,
    output logic                ie_o,
    output logic                src_o,
    output logic                flag_o,
    output logic                irq_o,
    output tmr_pkg::tmr_state_e state_o
);
    import tmr_pkg::*;

    localparam logic SRC_RST = (HAS_REF == 0);

    tmr_state_e       state_q, state_n;
    logic [CNT_W-1:0] count_q, reload_q;
    logic             en_q, ie_q, src_q, flag_q, irq_q;
    logic             step, wrap, reach0, expire_zero;

    assign step        = (state_q == ST_RUN) && tick_en && !wr_cur;
    assign wrap        = step && (count_q == CNT_W'(1));
    assign reach0      = step && (count_q == '0);
    assign expire_zero = (wrap || reach0 || wr_cur) && (reload_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state: start, stop, expire_zero
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_ctrl && ctl_wdata[CTL_EN_BIT]) state_n = ST_RUN;
            ST_RUN: begin
                if (wr_ctrl && !ctl_wdata[CTL_EN_BIT]) state_n = ST_IDLE;
                else if (expire_zero)                  state_n = ST_HALT;
            end
            ST_HALT: if (wr_ctrl && !ctl_wdata[CTL_EN_BIT]) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            en_q     <= 1'b0;
            ie_q     <= 1'b0;
            src_q    <= SRC_RST;
            flag_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= ctl_wdata[CTL_EN_BIT];
                ie_q  <= ctl_wdata[CTL_IE_BIT];
                src_q <= ctl_wdata[CTL_SRC_BIT] | SRC_RST;
            end
            if (wr_reload) reload_q <= rel_wdata;

            if (wr_cur)      count_q <= '0;
            else if (reach0) count_q <= reload_q;
            else if (step)   count_q <= count_q - CNT_W'(1);

            if (wr_cur)       flag_q <= 1'b0;
            else if (wrap)    flag_q <= 1'b1;
            else if (rd_ctrl) flag_q <= 1'b0;

            irq_q <= wrap & ie_q;
        end
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign en_o     = en_q;
    assign ie_o     = ie_q;
    assign src_o    = src_q;
    assign flag_o   = flag_q;
    assign irq_o    = irq_q;
    assign state_o  = state_q;
endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer #(
    parameter int CNT_W   = 24,
    parameter int ADDR_W  = 4,
    parameter int HAS_REF = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_tick_i,
    input  logic [23:0]             cal_count_i,
    input  logic                    cal_inexact_i,
    input  logic                    req_valid_i,
    input  logic                    req_write_i,
    input  logic                    req_user_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [31:0]             req_wdata_i,
    output logic [31:0]             rsp_rdata_o,
    output logic                    rsp_err_o,
    output logic                    irq_o
);
    import tmr_pkg::*;

    localparam logic REF_PRESENT = (HAS_REF != 0);

    logic             rd_ok, wr_ctrl, wr_reload, wr_cur, rd_ctrl;
    logic             sel_ctrl, sel_reload, sel_cur, sel_cal;
    logic             tick_en;
    logic [CNT_W-1:0] count, reload;
    logic             ctl_en, ctl_ie, ctl_src, ctl_flag;
    tmr_state_e       state;
    logic             unused_wdata;

    assign unused_wdata = ^req_wdata_i[REG_W-1:CNT_W];

    tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid      (req_valid_i),
        .write      (req_write_i),
        .user       (req_user_i),
        .addr       (req_addr_i),
        .acc_err    (rsp_err_o),
        .rd_ok      (rd_ok),
        .wr_ctrl    (wr_ctrl),
        .wr_reload  (wr_reload),
        .wr_cur     (wr_cur),
        .rd_ctrl    (rd_ctrl),
        .sel_ctrl   (sel_ctrl),
        .sel_reload (sel_reload),
        .sel_cur    (sel_cur),
        .sel_cal    (sel_cal)
    );

    tmr_tick_sel #(.HAS_REF(HAS_REF)) u_tick (
        .src_core (ctl_src),
        .ref_tick (ref_tick_i),
        .tick_en  (tick_en)
    );

    tmr_core #(.CNT_W(CNT_W), .HAS_REF(HAS_REF)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wr_cur    (wr_cur),
        .rd_ctrl   (rd_ctrl),
        .ctl_wdata (req_wdata_i[2:0]),
        .rel_wdata (req_wdata_i[CNT_W-1:0]),
        .count_o   (count),
        .reload_o  (reload),
        .en_o      (ctl_en),
        .ie_o      (ctl_ie),
        .src_o     (ctl_src),
        .flag_o    (ctl_flag),
        .irq_o     (irq_o),
        .state_o   (state)
    );

    always_comb begin
        rsp_rdata_o = '0;
        if (rd_ok) begin
            if (sel_ctrl) begin
                rsp_rdata_o[CTL_EN_BIT]   = ctl_en;
                rsp_rdata_o[CTL_IE_BIT]   = ctl_ie;
                rsp_rdata_o[CTL_SRC_BIT]  = ctl_src;
                rsp_rdata_o[CTL_FLAG_BIT] = ctl_flag;
            end else if (sel_reload) begin
                rsp_rdata_o = REG_W'(reload);
            end else if (sel_cur) begin
                rsp_rdata_o = REG_W'(count);
            end else if (sel_cal) begin
                rsp_rdata_o[CAL_NOREF_BIT]     = !REF_PRESENT;
                rsp_rdata_o[CAL_INEXACT_BIT]   = cal_inexact_i & REF_PRESENT;
                rsp_rdata_o[CAL_CNT_W-1:0]     = cal_count_i & {CAL_CNT_W{REF_PRESENT}};
            end
        end
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int CNT_W   = 24,
    parameter int HAS_REF = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid_i,
    input logic                req_user_i,
    input logic                req_write_i,
    input logic                rsp_err_o,
    input logic [31:0]         rsp_rdata_o,
    input logic                irq_o,
    input logic                ctl_flag,
    input logic                ctl_en,
    input logic                ctl_src,
    input tmr_pkg::tmr_state_e state,
    input logic [CNT_W-1:0]    count,
    input logic [CNT_W-1:0]    reload,
    input logic                wr_cur
);
    import tmr_pkg::*;

    localparam logic NO_REF = (HAS_REF == 0);

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctl_flag);

    // R9
    halt_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> ctl_en);

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wr_cur) |=> $stable(count));

    // R11
    user_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_user_i) |-> (rsp_err_o && rsp_rdata_o == '0));

    // R11
    user_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_user_i && req_write_i) |=> $stable(reload));

    // R13
    noref_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        NO_REF |-> ctl_src);
endmodule

bind periodic_down_timer tmr_chk #(.CNT_W(CNT_W), .HAS_REF(HAS_REF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_user_i  (req_user_i),
    .req_write_i (req_write_i),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o),
    .irq_o       (irq_o),
    .ctl_flag    (ctl_flag),
    .ctl_en      (ctl_en),
    .ctl_src     (ctl_src),
    .state       (state),
    .count       (count),
    .reload      (reload),
    .wr_cur      (wr_cur)
);

// File: tb/sim_periodic_down_timer.sv
module sim_periodic_down_timer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // instance u0: HAS_REF=1, CNT_W=24
    logic        ref_tick = 1'b0;
    logic [23:0] cal_cnt = 24'h0F423F;
    logic        cal_inx = 1'b1;
    logic        v = 1'b0, w = 1'b0, u = 1'b0;
    logic [3:0]  a = '0;
    logic [31:0] d = '0;
    logic [31:0] rdata;
    logic        err, irq;

    periodic_down_timer u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
        .cal_count_i(cal_cnt), .cal_inexact_i(cal_inx),
        .req_valid_i(v), .req_write_i(w), .req_user_i(u),
        .req_addr_i(a), .req_wdata_i(d),
        .rsp_rdata_o(rdata), .rsp_err_o(err), .irq_o(irq)
    );

    // instance u1: no reference, CNT_W=8
    logic        v1 = 1'b0, w1 = 1'b0;
    logic [3:0]  a1 = '0;
    logic [31:0] d1 = '0;
    logic [31:0] rdata1;
    logic        err1, irq1;

    periodic_down_timer #(.CNT_W(8), .HAS_REF(0)) u1 (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(1'b1),
        .cal_count_i(24'hABCDEF), .cal_inexact_i(1'b1),
        .req_valid_i(v1), .req_write_i(w1), .req_user_i(1'b0),
        .req_addr_i(a1), .req_wdata_i(d1),
        .rsp_rdata_o(rdata1), .rsp_err_o(err1), .irq_o(irq1)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model of u0 ----------------
    int          m_st;          // 0 idle, 1 run, 2 halt
    logic [23:0] m_cnt, m_rel;
    bit          m_en, m_ie, m_src, m_flag, m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_rel = 0;
            m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
        end else begin
            bit ok, wc, wrl, wv, rc, tick, wrap, hit0, stop;
            logic [23:0] nc;
            ok   = v && !u;
            wc   = ok && w && a == 4'h0;
            wrl  = ok && w && a == 4'h4;
            wv   = ok && w && a == 4'h8;
            rc   = ok && !w && a == 4'h0;
            tick = (m_st == 1) && (m_src || ref_tick);
            wrap = 0; hit0 = 0; nc = m_cnt;
            if (wv) nc = 0;
            else if (tick) begin
                if (m_cnt == 0) begin nc = m_rel; hit0 = 1; end
                else begin
                    nc = m_cnt - 1;
                    if (m_cnt == 1) begin wrap = 1; hit0 = 1; end
                end
            end
            stop = (wv || hit0) && (m_rel == 0);
            if (wc && !d[0]) m_st = 0;
            else if (wc && d[0] && m_st == 0) m_st = 1;
            else if (m_st == 1 && stop) m_st = 2;
            if (wv) m_flag = 0;
            else if (wrap) m_flag = 1;
            else if (rc) m_flag = 0;
            m_irq = wrap && m_ie;
            if (wc) begin m_en = d[0]; m_ie = d[1]; m_src = d[2]; end
            if (wrl) m_rel = d[23:0];
            m_cnt = nc;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] ad);
        case (ad)
            4'h0: exp_rd = {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
            4'h4: exp_rd = {8'b0, m_rel};
            4'h8: exp_rd = {8'b0, m_cnt};
            4'hC: exp_rd = {1'b0, cal_inx, 6'b0, cal_cnt};
            default: exp_rd = '0;
        endcase
    endfunction

    // interrupt output compared with the model on every clock (R6)
    always @(negedge clk) begin
        if (rst_n) chk(irq == m_irq, "R6 irq", {31'b0, irq}, {31'b0, m_irq});
    end

    // one bus cycle on u0, starting at a negedge
    task automatic acc(input bit wr, input bit usr, input logic [3:0] ad,
                       input logic [31:0] wd, input string req, output logic [31:0] got);
        logic [31:0] e;
        v = 1'b1; w = wr; u = usr; a = ad; d = wd;
        #1;
        got = rdata;
        if (usr) begin
            chk(err && rdata == 0, req, {rdata[30:0], err}, 32'h1);
        end else begin
            chk(!err, req, {31'b0, err}, 32'h0);
            if (!wr) begin
                e = exp_rd(ad);
                chk(rdata == e, req, rdata, e);
            end
        end
        @(negedge clk);
        v = 1'b0; w = 1'b0; u = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acc1(input bit wr, input logic [3:0] ad, input logic [31:0] wd,
                        output logic [31:0] got);
        v1 = 1'b1; w1 = wr; a1 = ad; d1 = wd;
        #1;
        got = rdata1;
        @(negedge clk);
        v1 = 1'b0; w1 = 1'b0;
    endtask

    bit ref_pat = 0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        ref_tick = ref_pat && (cyc % 3 == 0);
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        acc(0, 0, 4'h0, 0, "R1 ctrl", r);  chk(r == 0, "R1 ctrl const", r, 0);
        acc(0, 0, 4'h4, 0, "R1 reload", r);
        acc(0, 0, 4'h8, 0, "R1 cur", r);   chk(r == 0, "R1 cur const", r, 0);
        // R14: calibration
        acc(0, 0, 4'hC, 0, "R14 cal", r);  chk(r == 32'h400F423F, "R14 cal const", r, 32'h400F423F);

        // R4: reload truncation
        acc(1, 0, 4'h4, 32'hFF000005, "R4 wr", r);
        acc(0, 0, 4'h4, 0, "R4 rd", r);    chk(r == 5, "R4 const", r, 5);

        // R2: only bits 2:0 written
        acc(1, 0, 4'h0, 32'hFFFF_FFF5, "R2 wr", r);
        acc(0, 0, 4'h0, 0, "R2 rd", r);    chk(r == 32'h5, "R2 const", r, 32'h5);

        // R5 / R7: count on core clock
        for (int i = 0; i < 6; i++) acc(0, 0, 4'h8, 0, "R5 cur", r);
        // R3: flag read then cleared
        idle(4);
        acc(0, 0, 4'h0, 0, "R3 rd1", r);
        acc(0, 0, 4'h0, 0, "R3 rd2", r);
        // R6: interrupt enabled
        acc(1, 0, 4'h0, 32'h7, "R6 wr", r);
        for (int i = 0; i < 20; i++) acc(0, 0, 4'h0, 0, "R3 R6 flag", r);
        // R7: period check via current value reads
        for (int i = 0; i < 8; i++) acc(0, 0, 4'h8, 0, "R7 cur", r);

        // R5: reference tick source
        acc(1, 0, 4'h0, 32'h3, "R5 src", r);
        ref_pat = 1;
        for (int i = 0; i < 30; i++) acc(0, 0, 4'h8, 0, "R5 ref", r);
        ref_pat = 0;
        acc(1, 0, 4'h0, 32'h7, "R5 back", r);
        idle(3);

        // R10: freeze and resume
        acc(1, 0, 4'h0, 32'h6, "R10 off", r);
        acc(0, 0, 4'h8, 0, "R10 a", r);
        idle(5);
        acc(0, 0, 4'h8, 0, "R10 b", r2);   chk(r2 == r, "R10 frozen", r2, r);
        acc(1, 0, 4'h0, 32'h7, "R10 on", r);
        for (int i = 0; i < 4; i++) acc(0, 0, 4'h8, 0, "R10 resume", r);

        // R8: current-value write
        acc(1, 0, 4'h8, 32'hDEADBEEF, "R8 wr", r);
        acc(0, 0, 4'h8, 0, "R8 cur", r);
        acc(0, 0, 4'h0, 0, "R8 ctrl", r);
        idle(3);

        // R9: expiry with zero reload halts
        acc(1, 0, 4'h4, 0, "R9 rel0", r);
        idle(10);
        acc(0, 0, 4'h0, 0, "R9 en", r);    chk(r[0] == 1'b1, "R9 en const", r, r | 1);
        acc(1, 0, 4'h4, 32'h3, "R9 rel3", r);
        acc(0, 0, 4'h8, 0, "R9 held a", r);
        idle(4);
        acc(0, 0, 4'h8, 0, "R9 held b", r2); chk(r2 == r, "R9 held const", r2, r);
        acc(1, 0, 4'h0, 32'h3, "R9 reen", r);
        for (int i = 0; i < 6; i++) acc(0, 0, 4'h8, 0, "R9 resume", r);
        acc(1, 0, 4'h0, 32'h0, "R9 stop", r);
        acc(1, 0, 4'h0, 32'h3, "R9 start", r);
        for (int i = 0; i < 10; i++) acc(0, 0, 4'h8, 0, "R9 run", r);

        // R8: current-value write with zero reload stops counting
        acc(1, 0, 4'h4, 0, "R8 rel0", r);
        acc(1, 0, 4'h8, 32'h1, "R8 wr0", r);
        idle(4);
        acc(0, 0, 4'h8, 0, "R8 stopped", r); chk(r == 0, "R8 stopped const", r, 0);

        // R11: unprivileged access
        acc(0, 0, 4'h4, 0, "R11 pre", r);
        acc(1, 1, 4'h4, 32'h55, "R11 wr", r2);
        acc(1, 1, 4'h0, 32'h0, "R11 wrctl", r2);
        acc(0, 1, 4'h4, 0, "R11 rd", r2);
        acc(0, 0, 4'h4, 0, "R11 post", r2); chk(r2 == r, "R11 unchanged", r2, r);
        acc(0, 0, 4'h0, 0, "R11 ctl", r2);  chk(r2[0] == 1'b1, "R11 en kept", r2, 32'h1);

        // R12: undefined offsets
        acc(0, 0, 4'h1, 0, "R12 rd1", r);   chk(r == 0, "R12 const", r, 0);
        acc(0, 0, 4'hE, 0, "R12 rdE", r);
        acc(1, 0, 4'h2, 32'h0, "R12 wr", r);
        acc(0, 0, 4'h0, 0, "R12 ctl", r);

        // R13: instance without reference
        acc1(0, 4'h0, 0, r);  chk(r == 32'h4, "R13 reset src", r, 32'h4);
        acc1(1, 4'h0, 0, r);
        acc1(0, 4'h0, 0, r);  chk(r == 32'h4, "R13 forced src", r, 32'h4);
        acc1(0, 4'hC, 0, r);  chk(r == 32'h8000_0000, "R13 cal", r, 32'h8000_0000);
        acc1(1, 4'h4, 32'h1FF, r);
        acc1(0, 4'h4, 0, r);  chk(r == 32'hFF, "R4 narrow", r, 32'hFF);
        acc1(1, 4'h0, 32'h1, r);
        idle(4);
        acc1(0, 4'h8, 0, r);  chk(r != 0 && r <= 32'hFF, "R13 core count", r, 32'hFC);
        acc1(0, 4'h0, 0, r);  chk(r == 32'h5, "R13 ctrl", r, 32'h5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule